// File: doc/BRIEF.md
# Edge-Selectable Request Latch for a Non-Maskable Interrupt

This block turns activity on an external infrared receiver pin into a held request on a non-maskable interrupt line. The raw pin is brought into the clock domain through a synchroniser. An edge of the polarity that software selects sets a capture latch. The request line the block drives is active low and is the inverse of that latch. While the input is disabled the line rests high, which means no request.

Software can sample the latch through a read strobe and clear it with a one-cycle pulse. A second state bit stands for the interrupt input of the core. It is set when the request line goes from high to low and stays set until the service acknowledge arrives, whatever software does to the capture latch. Because it is non-maskable, this request can break into a normal interrupt routine that is already running. Only the acknowledge ends it.

Top module: `nmi_edge_latch`

## Requirements
- R1: After reset, `reqN` is 1, `latchRd` is 0 and `nmiPending` is 0. The synchroniser gets SYNC_STAGES+1 cycles to fill before any edge is accepted.
- R2: With `edgeSel` = 1 (rising) and `enable` = 1, a 0-to-1 change of `pinRaw` applied before clock edge k sets the latch. `reqN` is 1 after edge k+1 and 0 after edge k+2 (default of two synchroniser stages).
- R3: With `edgeSel` = 0 (falling) and `enable` = 1, a 1-to-0 change of `pinRaw` sets the latch with the same timing as R2.
- R4: An edge of the polarity that is not selected leaves the latch clear.
- R5: While `enable` is 0, `reqN` is 1 in the same cycle and pin edges do not set the latch. A latch that was already set is kept, and `reqN` goes low again when `enable` returns to 1.
- R6: A cycle with `readStrobe` = 1 loads the latch state into `latchRd` at the next clock edge. Without the strobe, `latchRd` holds its value.
- R7: A one-cycle `swClear` with no qualifying edge clears the latch, and `reqN` is 1 after that clock edge.
- R8: If `swClear` and a qualifying edge land in the same cycle, the edge wins and the latch stays set.
- R9: Changing `edgeSel` while the pin is steady does not set the latch.
- R10: `nmiPending` becomes 1 one clock edge after `reqN` falls. It is cleared only by `nmiAck`, and `swClear` or a rising `reqN` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinRaw | input | 1 | Asynchronous infrared receiver pin |
| edgeSel | input | 1 | Edge polarity: 1 rising, 0 falling |
| enable | input | 1 | Input enable at the latch |
| swClear | input | 1 | Software clear pulse for the capture latch |
| readStrobe | input | 1 | Loads the latch state into `latchRd` |
| nmiAck | input | 1 | Service acknowledge of the interrupt |
| reqN | output | 1 | Active-low request, inverse of the latch, high when disabled |
| latchRd | output | 1 | Software-readable copy of the latch |
| nmiPending | output | 1 | Request held on the interrupt input until acknowledged |

## Verification
A capture latch stuck low shows up three clock edges after a qualifying pin change: `reqN` stays high and the next read returns 0. A latch that sets spuriously or fails to clear shows as `reqN` low, or a read of 1, right after a wrong-polarity edge, an `edgeSel` toggle or a `swClear`. A pending bit that follows `swClear` instead of the acknowledge is seen at `nmiPending` one edge after the clear pulse. The clear/edge collision is placed in the exact cycle the qualified edge is present, so a reversed priority shows as `reqN` high one edge later.

// File: rtl/nmi_edge_latch_pkg.sv
package nmi_edge_latch_pkg;

  localparam logic EDGE_RISING  = 1'b1;
  localparam logic EDGE_FALLING = 1'b0;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic loadRead;
    logic setPend;
    logic clrPend;
  } latchStrobe_t;

endpackage

// File: rtl/nmi_edge_latch_dp.sv
module nmi_edge_latch_dp
  import nmi_edge_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinRaw,
  input  logic         enable,
  input  latchStrobe_t strobe,
  output logic         pinNow,
  output logic         pinPrev,
  output logic         primed,
  output logic         reqNow,
  output logic         reqPrev,
  output logic         latchQ,
  output logic         latchRd,
  output logic         pendQ
);

  localparam int PRIME_CNT = SYNC_STAGES + 1;
  localparam int CNT_W     = $clog2(PRIME_CNT + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [CNT_W-1:0]       primeCnt;

  // Synchroniser chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= pinRaw;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  // Edge detection stays blind until the chain holds real pin samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             primeCnt <= '0;
    else if (primeCnt != CNT_W'(PRIME_CNT)) primeCnt <= primeCnt + 1'b1;
  end

  assign primed  = (primeCnt == CNT_W'(PRIME_CNT));
  assign pinNow  = syncQ[SYNC_STAGES-1];
  assign pinPrev = prevQ;

  // Capture latch: set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                latchQ <= 1'b0;
    else if (strobe.setLatch) latchQ <= 1'b1;
    else if (strobe.clrLatch) latchQ <= 1'b0;
  end

  assign reqNow = ~(latchQ & enable);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrev <= 1'b1;
    else       reqPrev <= reqNow;
  end

  // Interrupt-side pending state, ended only by the acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pendQ <= 1'b0;
    else if (strobe.setPend) pendQ <= 1'b1;
    else if (strobe.clrPend) pendQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                latchRd <= 1'b0;
    else if (strobe.loadRead) latchRd <= latchQ;
  end

endmodule

// File: rtl/nmi_edge_latch_ctl.sv
module nmi_edge_latch_ctl
  import nmi_edge_latch_pkg::*;
(
  input  logic         pinNow,
  input  logic         pinPrev,
  input  logic         primed,
  input  logic         edgeSel,
  input  logic         enable,
  input  logic         swClear,
  input  logic         readStrobe,
  input  logic         nmiAck,
  input  logic         reqNow,
  input  logic         reqPrev,
  output latchStrobe_t strobe
);

  logic riseSeen;
  logic fallSeen;
  logic edgeHit;

  // Only pin samples are compared, so an edgeSel change alone sets nothing
  assign riseSeen = pinNow & ~pinPrev;
  assign fallSeen = ~pinNow & pinPrev;
  assign edgeHit  = primed & enable &
                    ((edgeSel == EDGE_RISING) ? riseSeen : fallSeen);

  always_comb begin
    strobe          = '0;
    strobe.setLatch = edgeHit;
    strobe.clrLatch = swClear;
    strobe.loadRead = readStrobe;
    strobe.setPend  = reqPrev & ~reqNow;
    strobe.clrPend  = nmiAck;
  end

endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch
  import nmi_edge_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic edgeSel,
  input  logic enable,
  input  logic swClear,
  input  logic readStrobe,
  input  logic nmiAck,
  output logic reqN,
  output logic latchRd,
  output logic nmiPending
);

  latchStrobe_t strobe;
  logic pinNow, pinPrev, primed, reqNow, reqPrev, latchQ;

  nmi_edge_latch_ctl u_ctl (
    .pinNow     (pinNow),
    .pinPrev    (pinPrev),
    .primed     (primed),
    .edgeSel    (edgeSel),
    .enable     (enable),
    .swClear    (swClear),
    .readStrobe (readStrobe),
    .nmiAck     (nmiAck),
    .reqNow     (reqNow),
    .reqPrev    (reqPrev),
    .strobe     (strobe)
  );

  nmi_edge_latch_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinRaw  (pinRaw),
    .enable  (enable),
    .strobe  (strobe),
    .pinNow  (pinNow),
    .pinPrev (pinPrev),
    .primed  (primed),
    .reqNow  (reqNow),
    .reqPrev (reqPrev),
    .latchQ  (latchQ),
    .latchRd (latchRd),
    .pendQ   (nmiPending)
  );

  assign reqN = reqNow;

endmodule

// File: rtl/nmi_edge_latch_chk.sv
module nmi_edge_latch_chk
  import nmi_edge_latch_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input logic         readStrobe,
  input logic         nmiAck,
  input logic         reqN,
  input logic         latchRd,
  input logic         nmiPending,
  input latchStrobe_t strobe,
  input logic         latchQ
);

  assert_set_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setLatch |=> latchQ);

  assert_clear_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrLatch && !strobe.setLatch) |=> !latchQ);

  assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> reqN);

  assert_read_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> (latchRd == $past(latchQ)));

  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |=> $stable(latchRd));

  assert_pend_on_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqN) |=> nmiPending);

  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPending && !nmiAck) |=> nmiPending);

endmodule

bind nmi_edge_latch nmi_edge_latch_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .readStrobe (readStrobe),
  .nmiAck     (nmiAck),
  .reqN       (reqN),
  .latchRd    (latchRd),
  .nmiPending (nmiPending),
  .strobe     (strobe),
  .latchQ     (latchQ)
);

// File: tb/nmi_edge_latch_bench.sv
module nmi_edge_latch_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinRaw = 1'b0;
  logic edgeSel = 1'b1;
  logic enable = 1'b1;
  logic swClear = 1'b0;
  logic readStrobe = 1'b0;
  logic nmiAck = 1'b0;
  logic reqN, latchRd, nmiPending;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nmi_edge_latch u_nmi_edge_latch (
    .clk        (clk),
    .rstN       (rstN),
    .pinRaw     (pinRaw),
    .edgeSel    (edgeSel),
    .enable     (enable),
    .swClear    (swClear),
    .readStrobe (readStrobe),
    .nmiAck     (nmiAck),
    .reqN       (reqN),
    .latchRd    (latchRd),
    .nmiPending (nmiPending)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    nChecks++;
    if (actual !== expected) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, actual, expected);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readLatch(output logic v);
    readStrobe = 1'b1;
    tick(1);
    readStrobe = 1'b0;
    v = latchRd;
  endtask

  task automatic clearLatch();
    swClear = 1'b1;
    tick(1);
    swClear = 1'b0;
  endtask

  task automatic ackNmi();
    nmiAck = 1'b1;
    tick(1);
    nmiAck = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    tick(3);
    check("R1 reqN in reset", reqN, 1'b1);
    check("R1 latchRd in reset", latchRd, 1'b0);
    check("R1 nmiPending in reset", nmiPending, 1'b0);
    rstN = 1'b1;
    tick(5);
    check("R1 reqN after release", reqN, 1'b1);
  endtask

  task automatic t_rise();
    logic v;
    edgeSel = 1'b1;
    pinRaw = 1'b1;
    tick(2);
    check("R2 reqN before edge k+2", reqN, 1'b1);
    tick(1);
    check("R2 reqN after edge k+2", reqN, 1'b0);
    check("R10 pending not yet", nmiPending, 1'b0);
    tick(1);
    check("R10 pending one edge after fall", nmiPending, 1'b1);
    readLatch(v);
    check("R6 read of set latch", v, 1'b1);
    tick(2);
    check("R6 latchRd holds", latchRd, 1'b1);
    clearLatch();
    check("R7 reqN after clear", reqN, 1'b1);
    check("R10 pending kept after swClear", nmiPending, 1'b1);
    readLatch(v);
    check("R7 read after clear", v, 1'b0);
    ackNmi();
    check("R10 pending cleared by ack", nmiPending, 1'b0);
  endtask

  task automatic t_fall();
    edgeSel = 1'b0;
    pinRaw = 1'b0;
    tick(2);
    check("R3 reqN before edge k+2", reqN, 1'b1);
    tick(1);
    check("R3 reqN after edge k+2", reqN, 1'b0);
    tick(1);
    check("R10 pending on falling select", nmiPending, 1'b1);
    clearLatch();
    ackNmi();
    check("R3 reqN after cleanup", reqN, 1'b1);
  endtask

  task automatic t_wrongEdge();
    logic v;
    edgeSel = 1'b0;
    pinRaw = 1'b1;
    tick(5);
    check("R4 rising ignored under falling select", reqN, 1'b1);
    readLatch(v);
    check("R4 latch clear after rising", v, 1'b0);
    edgeSel = 1'b1;
    tick(2);
    pinRaw = 1'b0;
    tick(5);
    check("R4 falling ignored under rising select", reqN, 1'b1);
    check("R4 no pending", nmiPending, 1'b0);
  endtask

  task automatic t_selToggle();
    logic v;
    edgeSel = 1'b0;
    tick(3);
    edgeSel = 1'b1;
    tick(3);
    edgeSel = 1'b0;
    tick(3);
    check("R9 reqN after select toggles", reqN, 1'b1);
    readLatch(v);
    check("R9 latch after select toggles", v, 1'b0);
    edgeSel = 1'b1;
    tick(2);
  endtask

  task automatic t_disable();
    logic v;
    enable = 1'b0;
    edgeSel = 1'b1;
    pinRaw = 1'b1;
    tick(5);
    check("R5 reqN high while disabled", reqN, 1'b1);
    readLatch(v);
    check("R5 edge ignored while disabled", v, 1'b0);
    enable = 1'b1;
    tick(2);
    edgeSel = 1'b0;
    tick(1);
    pinRaw = 1'b0;
    tick(4);
    check("R3 reqN low before disable", reqN, 1'b0);
    ackNmi();
    enable = 1'b0;
    #1;
    check("R5 reqN high at once on disable", reqN, 1'b1);
    tick(3);
    check("R5 pending not raised while high", nmiPending, 1'b0);
    enable = 1'b1;
    #1;
    check("R5 latch kept, reqN low on re-enable", reqN, 1'b0);
    tick(1);
    check("R10 pending on re-enable fall", nmiPending, 1'b1);
    clearLatch();
    ackNmi();
  endtask

  task automatic t_race();
    logic v;
    edgeSel = 1'b1;
    pinRaw = 1'b1;
    tick(2);
    swClear = 1'b1;
    tick(1);
    swClear = 1'b0;
    check("R8 edge wins over clear", reqN, 1'b0);
    readLatch(v);
    check("R8 latch set after collision", v, 1'b1);
    clearLatch();
    check("R7 reqN after later clear", reqN, 1'b1);
    ackNmi();
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_wrongEdge();
    t_selToggle();
    t_disable();
    t_race();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule